// File: doc/BRIEF.md
# Slave Host Interface with Status Register

This block is the host-facing side of a small peripheral controller. An external bus master reaches it with a chip select, read and write strobes and one address bit that tells command from data. Behind this port sit an input buffer filled by the master, an output buffer filled by the local core, and an 8-bit status register. The status register holds the two buffer-full flags, two general flags (F0 and F1) and four bits the core defines. The local core drives a set of single-cycle controls. They load the output buffer, take the input buffer, write the upper status nibble, write F0, write the upper port latch, and switch the upper port pins into their handshake roles.

All host inputs are sampled on the block clock. An access is tracked by a four-state machine: `HS_IDLE`, `HS_WR_HOLD` (host write strobe active), `HS_RD_DATA` (host reading the output buffer) and `HS_RD_STAT` (host reading status). The transitions are:
- `HS_IDLE` to `HS_WR_HOLD` on a selected write. Write has priority over read.
- `HS_IDLE` to `HS_RD_STAT` on a selected read with address bit 1.
- `HS_IDLE` to `HS_RD_DATA` on a selected read with address bit 0.
- Each active state back to `HS_IDLE` once its strobe, or the selection, goes away.

That return edge is the trailing edge, and buffer flags change only there. While the machine sits in `HS_RD_STAT`, core-side changes to status are parked and applied once the read ends.

Four upper port pins can be used as plain latch outputs or as handshake pins:
- An output-full interrupt.
- An input-ready interrupt.
- A DMA request.
- A DMA acknowledge input, which then acts as a chip select for the data buffers.

Top module: `host_slave_if`

## Requirements
- R1: Status layout is bit 0 output-full, bit 1 input-full, bit 2 F0, bit 3 F1, bits 7:4 user bits. After reset, status is 0x00, the port latch is 4'b1111, and `port_hs` equals the latch (plain port pins).
- R2: A selected host write stores `host_wdata` into the input buffer, sets input-full and loads F1 with the address bit (1 = command, 0 = data). These updates happen on the first clock edge that samples the strobe or select low, and not earlier.
- R3: A host read with `host_cs`=1 and `host_a0`=1 returns the status register on `host_rdata`; otherwise it returns the output buffer. A completed read of the output buffer clears output-full on its trailing edge.
- R4: `core_read_ibuf` clears input-full, and `core_load_obuf` writes `core_wdata` to the output buffer and sets output-full. On a clash in the same cycle, the core load beats the host clear of output-full, and a host write commit beats the core clear of input-full.
- R5: `core_wr_ustat` copies `core_wdata[7:4]` into status bits 7:4 and leaves bits 3:0 unchanged. F0 changes only through `core_f0_wr`, which loads `core_f0`.
- R6: While the state is `HS_RD_STAT`, status does not change. Core status updates made in that window are held (the latest value for the user bits and F0) and take effect on the clock edge after the state leaves `HS_RD_STAT`. The output buffer contents still update at once.
- R7: After `core_en_flags` (sticky until reset), `port_hs[0]` equals latch bit 0 AND output-full, and `port_hs[1]` equals latch bit 1 AND NOT input-full.
- R8: After `core_en_dma`, a port write with `core_wdata[6]`=1 raises the DMA request on `port_hs[2]`. The request is cleared by `host_dack` together with `host_rd` or `host_wr`, or by `core_en_dma` again, and `core_en_dma` has the highest priority. In DMA mode `port_hs[3]` is driven 1 so that it can serve as the acknowledge input.
- R9: In DMA mode, `host_dack` selects the data buffers as if `host_cs`=1 with `host_a0`=0, so a write under acknowledge clears F1.
- R10: The access state machine follows the transitions listed above, entering `HS_WR_HOLD` the cycle after a selected write is sampled in `HS_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host chip select, active high |
| host_dack | input | 1 | DMA acknowledge from the DMA controller, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_a0 | input | 1 | Address bit: 1 command/status, 0 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status or output buffer toward the host |
| core_load_obuf | input | 1 | Core writes `core_wdata` to the output buffer |
| core_read_ibuf | input | 1 | Core takes the input buffer |
| core_wr_ustat | input | 1 | Core writes status bits 7:4 from `core_wdata[7:4]` |
| core_f0_wr | input | 1 | Core writes F0 |
| core_f0 | input | 1 | Value for F0 |
| core_port_wr | input | 1 | Core writes the port latch from `core_wdata[7:4]` |
| core_en_flags | input | 1 | Switch port bits 4 and 5 to buffer-flag interrupts |
| core_en_dma | input | 1 | Switch port bits 6 and 7 to DMA handshake; clears the request |
| core_wdata | input | 8 | Core data bus |
| core_ibuf | output | 8 | Input buffer contents toward the core |
| core_status | output | 8 | Status register toward the core |
| port_hs | output | 4 | Port pins for bits 7:4 (index 0 is port bit 4) |

## Verification
The hardest situation to reach is a core update that lands while a status read is under way. The parked value must show up exactly one edge after the read ends, and stay invisible until then. The stimulus holds a status read open for several cycles and pulses output loads, user-status writes, F0 writes and an input-buffer take inside that window, then releases the strobe. A second hard case is the DMA request racing its clear paths. Acknowledged reads and writes are driven with `host_cs` low, and enable-DMA is issued while a request is pending. The bench reference model is compared every clock, so both timing slips and wrong values show up.

// File: rtl/hif_pkg.sv
package hif_pkg;
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_WR_HOLD = 2'd1,
        HS_RD_DATA = 2'd2,
        HS_RD_STAT = 2'd3
    } hs_state_e;

    localparam int ST_OBF    = 0;
    localparam int ST_IBF    = 1;
    localparam int ST_F0     = 2;
    localparam int ST_F1     = 3;
    localparam int ST_USR_LO = 4;
    localparam int HS_W      = 4;
endpackage

// File: rtl/hif_host_fsm.sv
module hif_host_fsm
    import hif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic wr,
    input  logic rd,
    input  logic a0e,
    output logic capture,
    output logic wr_commit,
    output logic rd_commit,
    output logic stat_lock
);
    hs_state_e state_q, state_d;
    logic wr_act, rd_act;

    assign wr_act = sel & wr;
    assign rd_act = sel & rd;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        capture   = wr_act;
        wr_commit = 1'b0;
        rd_commit = 1'b0;
        stat_lock = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (wr_act)      state_d = HS_WR_HOLD;
                else if (rd_act) state_d = a0e ? HS_RD_STAT : HS_RD_DATA;
            end
            HS_WR_HOLD: begin
                if (!wr_act) begin
                    state_d   = HS_IDLE;
                    wr_commit = 1'b1;
                end
            end
            HS_RD_DATA: begin
                if (!rd_act) begin
                    state_d   = HS_IDLE;
                    rd_commit = 1'b1;
                end
            end
            HS_RD_STAT: begin
                stat_lock = 1'b1;
                if (!rd_act) state_d = HS_IDLE;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    // R10: selected write sampled in idle enters the write-hold state
    p_wr_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && sel && wr) |=> (state_q == HS_WR_HOLD));

    // R10: selected status read enters the status-read state
    p_stat_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && sel && rd && !wr && a0e) |=> (state_q == HS_RD_STAT));
endmodule

// File: rtl/hif_flags.sv
module hif_flags
    import hif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] host_wdata,
    input  logic          a0e,
    input  logic          wr_commit,
    input  logic          rd_commit,
    input  logic          stat_lock,
    input  logic          core_load,
    input  logic          core_rd,
    input  logic          core_wr_ustat,
    input  logic          core_f0_wr,
    input  logic          core_f0,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] status,
    output logic [DW-1:0] obuf,
    output logic [DW-1:0] ibuf
);
    localparam int USR_W = DW - ST_USR_LO;

    logic [DW-1:0]    wr_data_q;
    logic             a0_q;
    logic             obf_q, ibf_q, f0_q, f1_q;
    logic [USR_W-1:0] usr_q;
    logic             pend_obf, pend_ibf, pend_usr, pend_f0;
    logic [USR_W-1:0] pend_usr_v;
    logic             pend_f0_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data_q  <= '0;
            a0_q       <= 1'b0;
            obuf       <= '0;
            ibuf       <= '0;
            obf_q      <= 1'b0;
            ibf_q      <= 1'b0;
            f0_q       <= 1'b0;
            f1_q       <= 1'b0;
            usr_q      <= '0;
            pend_obf   <= 1'b0;
            pend_ibf   <= 1'b0;
            pend_usr   <= 1'b0;
            pend_f0    <= 1'b0;
            pend_usr_v <= '0;
            pend_f0_v  <= 1'b0;
        end else begin
            if (core_load) obuf <= core_wdata;
            if (wr_commit) ibuf <= wr_data_q;
            if (capture) begin
                wr_data_q <= host_wdata;
                a0_q      <= a0e;
            end
            if (!stat_lock) begin
                if (core_load || pend_obf) obf_q <= 1'b1;
                else if (rd_commit)        obf_q <= 1'b0;
                if (wr_commit)                ibf_q <= 1'b1;
                else if (core_rd || pend_ibf) ibf_q <= 1'b0;
                if (wr_commit) f1_q <= a0_q;
                if (core_wr_ustat) usr_q <= core_wdata[DW-1:ST_USR_LO];
                else if (pend_usr) usr_q <= pend_usr_v;
                if (core_f0_wr)    f0_q <= core_f0;
                else if (pend_f0)  f0_q <= pend_f0_v;
                pend_obf <= 1'b0;
                pend_ibf <= 1'b0;
                pend_usr <= 1'b0;
                pend_f0  <= 1'b0;
            end else begin
                if (core_load) pend_obf <= 1'b1;
                if (core_rd)   pend_ibf <= 1'b1;
                if (core_wr_ustat) begin
                    pend_usr   <= 1'b1;
                    pend_usr_v <= core_wdata[DW-1:ST_USR_LO];
                end
                if (core_f0_wr) begin
                    pend_f0   <= 1'b1;
                    pend_f0_v <= core_f0;
                end
            end
        end
    end

    always_comb begin
        status                      = '0;
        status[ST_OBF]              = obf_q;
        status[ST_IBF]              = ibf_q;
        status[ST_F0]               = f0_q;
        status[ST_F1]               = f1_q;
        status[DW-1:ST_USR_LO]      = usr_q;
    end

    // R6: status frozen while the host reads it
    p_status_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_lock |=> $stable(status));

    // R2: write commit leaves input-full set
    p_ibf_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !stat_lock) |=> status[ST_IBF]);

    // R2: F1 takes the address bit captured with the write
    p_f1_tracks_a0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !stat_lock) |=> (status[ST_F1] == $past(a0_q)));

    // R4: core load outside lockout leaves output-full set
    p_obf_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_load && !stat_lock) |=> status[ST_OBF]);

    // R4: core read clears input-full when no host write commits
    p_ibf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd && !stat_lock && !wr_commit) |=> !status[ST_IBF]);
endmodule

// File: rtl/hif_handshake.sv
module hif_handshake
    import hif_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_wr,
    input  logic [HS_W-1:0] port_val,
    input  logic            en_flags,
    input  logic            en_dma,
    input  logic            dack,
    input  logic            rd,
    input  logic            wr,
    input  logic            obf,
    input  logic            ibf,
    output logic            dma_en,
    output logic [HS_W-1:0] port_hs
);
    logic [HS_W-1:0] latch_q;
    logic            flags_en_q, dma_en_q, drq_q;
    logic            ack_clr;

    assign ack_clr = dma_en_q & dack & (rd | wr);
    assign dma_en  = dma_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q    <= '1;
            flags_en_q <= 1'b0;
            dma_en_q   <= 1'b0;
            drq_q      <= 1'b0;
        end else begin
            if (port_wr)  latch_q    <= port_val;
            if (en_flags) flags_en_q <= 1'b1;
            if (en_dma) begin
                dma_en_q <= 1'b1;
                drq_q    <= 1'b0;
            end else if (ack_clr) begin
                drq_q <= 1'b0;
            end else if (dma_en_q && port_wr && port_val[2]) begin
                drq_q <= 1'b1;
            end
        end
    end

    always_comb begin
        port_hs[0] = flags_en_q ? (latch_q[0] & obf)  : latch_q[0];
        port_hs[1] = flags_en_q ? (latch_q[1] & ~ibf) : latch_q[1];
        port_hs[2] = dma_en_q   ? drq_q               : latch_q[2];
        port_hs[3] = dma_en_q   ? 1'b1                : latch_q[3];
    end

    // R8: enable-DMA always leaves the request low
    p_drq_clr_endma_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_dma |=> !drq_q);

    // R8: an acknowledged strobe clears the request
    p_drq_clr_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en_q && dack && (rd || wr)) |=> !drq_q);

    // R7: flag mode stays on once enabled
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_en_q |=> flags_en_q);
endmodule

// File: rtl/host_slave_if.sv
module host_slave_if
    import hif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs,
    input  logic          host_dack,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic          host_a0,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          core_load_obuf,
    input  logic          core_read_ibuf,
    input  logic          core_wr_ustat,
    input  logic          core_f0_wr,
    input  logic          core_f0,
    input  logic          core_port_wr,
    input  logic          core_en_flags,
    input  logic          core_en_dma,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_ibuf,
    output logic [DW-1:0] core_status,
    output logic [HS_W-1:0] port_hs
);
    logic          dma_en, sel, a0e;
    logic          capture, wr_commit, rd_commit, stat_lock;
    logic [DW-1:0] status, obuf;

    assign sel = host_cs | (dma_en & host_dack);
    assign a0e = host_cs & host_a0;

    hif_host_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr        (host_wr),
        .rd        (host_rd),
        .a0e       (a0e),
        .capture   (capture),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .stat_lock (stat_lock)
    );

    hif_flags #(.DW(DW)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (capture),
        .host_wdata    (host_wdata),
        .a0e           (a0e),
        .wr_commit     (wr_commit),
        .rd_commit     (rd_commit),
        .stat_lock     (stat_lock),
        .core_load     (core_load_obuf),
        .core_rd       (core_read_ibuf),
        .core_wr_ustat (core_wr_ustat),
        .core_f0_wr    (core_f0_wr),
        .core_f0       (core_f0),
        .core_wdata    (core_wdata),
        .status        (status),
        .obuf          (obuf),
        .ibuf          (core_ibuf)
    );

    hif_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_wr  (core_port_wr),
        .port_val (core_wdata[DW-1:DW-HS_W]),
        .en_flags (core_en_flags),
        .en_dma   (core_en_dma),
        .dack     (host_dack),
        .rd       (host_rd),
        .wr       (host_wr),
        .obf      (status[ST_OBF]),
        .ibf      (status[ST_IBF]),
        .dma_en   (dma_en),
        .port_hs  (port_hs)
    );

    assign host_rdata  = a0e ? status : obuf;
    assign core_status = status;
endmodule

// File: tb/host_slave_if_tb.sv
module host_slave_if_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 0, dack = 0, rd = 0, wr = 0, a0 = 0;
    logic [7:0] hwd = 0;
    logic ld = 0, crd = 0, wus = 0, f0w = 0, f0v = 0, pw = 0, ef = 0, ed = 0;
    logic [7:0] cwd = 0;
    logic [7:0] rdata, cibuf, cstat;
    logic [3:0] phs;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    host_slave_if dut_i (
        .clk(clk), .rst_n(rst_n), .host_cs(cs), .host_dack(dack), .host_rd(rd),
        .host_wr(wr), .host_a0(a0), .host_wdata(hwd), .host_rdata(rdata),
        .core_load_obuf(ld), .core_read_ibuf(crd), .core_wr_ustat(wus),
        .core_f0_wr(f0w), .core_f0(f0v), .core_port_wr(pw), .core_en_flags(ef),
        .core_en_dma(ed), .core_wdata(cwd), .core_ibuf(cibuf), .core_status(cstat),
        .port_hs(phs)
    );

    // behavioural reference model
    int m_st;
    bit m_obf, m_ibf, m_f0, m_f1, m_a0q, m_fl, m_dma, m_drq;
    bit [3:0] m_usr, m_lat, m_pusv;
    bit [7:0] m_obuf, m_ibuf, m_wq;
    bit m_pobf, m_pibf, m_pus, m_pf0, m_pf0v;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit sel, a0e, wa, ra, lk, cw, cr, ackc;
        if (!rst_n) begin
            m_st = 0; m_obf = 0; m_ibf = 0; m_f0 = 0; m_f1 = 0; m_a0q = 0;
            m_fl = 0; m_dma = 0; m_drq = 0; m_usr = 0; m_lat = 4'hF; m_pusv = 0;
            m_obuf = 0; m_ibuf = 0; m_wq = 0; m_pobf = 0; m_pibf = 0;
            m_pus = 0; m_pf0 = 0; m_pf0v = 0;
        end else begin
            sel = cs | (m_dma & dack);
            a0e = cs & a0;
            wa = sel & wr;
            ra = sel & rd;
            lk = (m_st == 3);
            cw = (m_st == 1) && !wa;
            cr = (m_st == 2) && !ra;
            ackc = m_dma & dack & (rd | wr);
            if (!lk) begin
                if (ld || m_pobf) m_obf = 1; else if (cr) m_obf = 0;
                if (cw) m_ibf = 1; else if (crd || m_pibf) m_ibf = 0;
                if (cw) m_f1 = m_a0q;
                if (wus) m_usr = cwd[7:4]; else if (m_pus) m_usr = m_pusv;
                if (f0w) m_f0 = f0v; else if (m_pf0) m_f0 = m_pf0v;
                m_pobf = 0; m_pibf = 0; m_pus = 0; m_pf0 = 0;
            end else begin
                if (ld) m_pobf = 1;
                if (crd) m_pibf = 1;
                if (wus) begin m_pus = 1; m_pusv = cwd[7:4]; end
                if (f0w) begin m_pf0 = 1; m_pf0v = f0v; end
            end
            if (ld) m_obuf = cwd;
            if (cw) m_ibuf = m_wq;
            if (wa) begin m_wq = hwd; m_a0q = a0e; end
            if (ed) begin m_dma = 1; m_drq = 0; end
            else if (ackc) m_drq = 0;
            else if (m_dma && pw && cwd[6]) m_drq = 1;
            if (pw) m_lat = cwd[7:4];
            if (ef) m_fl = 1;
            case (m_st)
                0: if (wa) m_st = 1; else if (ra) m_st = a0e ? 3 : 2;
                1: if (!wa) m_st = 0;
                2: if (!ra) m_st = 0;
                default: if (!ra) m_st = 0;
            endcase
        end
        #(CLK_P/4);
        if (!done) begin
            bit [7:0] est;
            bit [3:0] ep;
            est = {m_usr, m_f1, m_f0, m_ibf, m_obf};
            ep[0] = m_fl ? (m_lat[0] & m_obf) : m_lat[0];
            ep[1] = m_fl ? (m_lat[1] & ~m_ibf) : m_lat[1];
            ep[2] = m_dma ? m_drq : m_lat[2];
            ep[3] = m_dma ? 1'b1 : m_lat[3];
            chk("R1 R2 R4 R6 status", cstat, est);
            chk("R2 R9 core_ibuf", cibuf, m_ibuf);
            chk("R3 host_rdata", rdata, (cs & a0) ? est : m_obuf);
            chk("R7 R8 port_hs", phs, ep);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(bit ad, bit [7:0] d, int hold);
        @(negedge clk); cs = 1; wr = 1; a0 = ad; hwd = d;
        idle(hold);
        cs = 0; wr = 0;
    endtask

    task automatic host_read(bit ad, int hold);
        @(negedge clk); cs = 1; rd = 1; a0 = ad;
        idle(hold);
        cs = 0; rd = 0;
    endtask

    task automatic pulse_core(ref logic s, input bit [7:0] d);
        @(negedge clk); s = 1; cwd = d;
        @(negedge clk); s = 0;
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        // R1 reset state checked every cycle by the model compare
        idle(2);
        // R2 data write, held for three cycles; R10 write-hold state
        host_write(0, 8'h5A, 3); idle(2);
        // R4 core takes the input buffer
        pulse_core(crd, 8'h00); idle(1);
        // R2 command write sets F1
        host_write(1, 8'hD1, 1); idle(2);
        // R4 core load, R3 host data read clears output-full
        pulse_core(ld, 8'hC3); idle(1);
        host_read(0, 2); idle(2);
        // R5 upper status and F0
        pulse_core(wus, 8'hAF); f0v = 1; pulse_core(f0w, 8'h00); idle(1);
        // R6 lockout: core activity during a long status read
        @(negedge clk); cs = 1; rd = 1; a0 = 1;
        idle(1); ld = 1; cwd = 8'h77;
        @(negedge clk); ld = 0; wus = 1; cwd = 8'h30;
        @(negedge clk); wus = 0; f0w = 1; f0v = 0;
        @(negedge clk); f0w = 0; crd = 1;
        @(negedge clk); crd = 0; wus = 1; cwd = 8'h90;
        @(negedge clk); wus = 0;
        idle(2); cs = 0; rd = 0;
        idle(3);
        // R4 clash: host write commit and core read in the same cycle
        @(negedge clk); cs = 1; wr = 1; a0 = 0; hwd = 8'h12;
        @(negedge clk); cs = 0; wr = 0; crd = 1;
        @(negedge clk); crd = 0;
        idle(2);
        // R7 flag pins: latch patterns before and after enable
        pulse_core(pw, 8'h30); idle(1);
        pulse_core(ef, 8'h00); idle(1);
        pulse_core(ld, 8'h44); idle(1);
        host_read(0, 1); idle(1);
        pulse_core(crd, 8'h00); idle(1);
        pulse_core(pw, 8'h00); idle(1);
        pulse_core(pw, 8'h30); idle(1);
        // R8 DMA request set and cleared by acknowledged read
        pulse_core(ed, 8'h00); idle(1);
        pulse_core(pw, 8'h70); idle(1);
        pulse_core(ld, 8'hE5); idle(1);
        @(negedge clk); dack = 1; rd = 1; a0 = 1;   // R9: cs low, dack selects data
        @(negedge clk); dack = 0; rd = 0; a0 = 0;
        idle(2);
        // R8 set again, cleared by acknowledged write; R9 write under dack clears F1
        host_write(1, 8'h01, 1); idle(1);
        pulse_core(pw, 8'h70); idle(1);
        @(negedge clk); dack = 1; wr = 1; hwd = 8'hB6;
        @(negedge clk); dack = 0; wr = 0;
        idle(2);
        // R8 set again, cleared by enable-DMA
        pulse_core(pw, 8'h70); idle(1);
        pulse_core(ed, 8'h00); idle(1);
        // R8 dack without strobe leaves the request
        pulse_core(pw, 8'h70);
        @(negedge clk); dack = 1;
        @(negedge clk); dack = 0;
        idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule